// File: doc/BRIEF.md
# SATA Port Soft-Reset Controller

This block is a simplified per-port controller for a host adapter. It keeps the command-issue bitmap for a fixed number of command slots. Software sets bits in the bitmap. Completions clear them. The block also watches host-to-device register frames to move the port between a running state and a held-in-reset state.

A legacy software reset uses two frames. The first frame raises the reset bit in the device-control byte. It gets no reply, and it releases its own slot only when its command header asks for busy to be cleared. The second frame drops the reset bit and causes a full port reset. A sideband pulse can also force the same port reset without using any slot.

After every port reset a programmable diagnostic delay runs. When the delay ends, the block emits a one-cycle device-to-host frame strobe and loads good status into the task-file register. It also loads the signature register from the four task-file bytes.

Top module: `sata_srst_port`

## Requirements
- R1: After rst_n is released, cmd_issue is 0, tfd is 0x7F, sig is 0xFFFFFFFF, in_reset is 0, init_d2h_sent is 0 and d2h_strobe is 0.
- R2: A cycle with issue_we high ORs issue_mask into cmd_issue. A cycle with cmpl_valid high clears bit cmpl_slot. Either result is visible on the next cycle, and this holds for slot 31 as for any other slot.
- R3: While running (in_reset 0), a valid frame with frm_bad low and bit 2 (mask 0x04) of frm_ctrl set makes in_reset 1 on the next cycle. The same frame with bit 2 clear leaves in_reset at 0 and leaves cmd_issue unchanged.
- R4: The reset-asserting frame of R3 clears bit frm_slot of cmd_issue only when frm_clr_busy is 1; with frm_clr_busy 0 the bitmap is unchanged. No d2h_strobe results from it.
- R5: While in_reset is 1, a valid good frame with bit 2 of frm_ctrl still set is ignored: in_reset stays 1 and cmd_issue is unchanged, whatever frm_clr_busy and frm_slot are.
- R6: While in_reset is 1, a valid good frame with bit 2 of frm_ctrl clear performs a port reset. On the next cycle cmd_issue is 0, tfd is 0x7F, sig is 0xFFFFFFFF, init_d2h_sent is 0 and in_reset is 0. This holds even when issue_we is high in the same cycle.
- R7: A one-cycle comreset pulse performs the same port reset from either state. It does not depend on any frame or slot input.
- R8: A port reset accepted at clock edge E gives exactly one d2h_strobe pulse. The pulse is high in the cycle after edge E+diag_cycles+1, and diag_cycles equal to 0 is allowed. In that cycle tfd is 0x50 and init_d2h_sent is 1. sig is {tf_cyl_hi, tf_cyl_lo, tf_sec_cnt, tf_sec_num}, with bits 31:24 first.
- R9: A frame with frm_bad high changes neither cmd_issue nor in_reset, so the slot of a frame that failed to parse stays set.
- R10: A new port reset that arrives while the diagnostic delay is still running restarts the delay. Only the later reset produces a strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_we | input | 1 | OR issue_mask into the command-issue bitmap |
| issue_mask | input | SLOTS | Slots to mark as issued |
| cmpl_valid | input | 1 | A command completed |
| cmpl_slot | input | $clog2(SLOTS) | Slot of the completed command |
| frm_valid | input | 1 | A host-to-device register frame is present |
| frm_bad | input | 1 | The frame failed to parse |
| frm_ctrl | input | 8 | Device-control byte of the frame; bit 2 is the reset bit |
| frm_clr_busy | input | 1 | Command-header option: clear busy on acknowledge |
| frm_slot | input | $clog2(SLOTS) | Slot the frame was fetched from |
| comreset | input | 1 | Sideband port-reset pulse |
| diag_cycles | input | DIAG_W | Diagnostic delay length in cycles |
| tf_cyl_hi | input | 8 | Task-file cylinder-high byte |
| tf_cyl_lo | input | 8 | Task-file cylinder-low byte |
| tf_sec_cnt | input | 8 | Task-file sector-count byte |
| tf_sec_num | input | 8 | Task-file sector-number byte |
| cmd_issue | output | SLOTS | Command-issue bitmap |
| tfd | output | 8 | Task-file status |
| sig | output | 32 | Device signature |
| in_reset | output | 1 | Port is held in the software-reset state |
| init_d2h_sent | output | 1 | The first device-to-host frame has been sent |
| d2h_strobe | output | 1 | One-cycle device-to-host register frame strobe |

## Verification
The bitmap, the state and the reset values of tfd and sig are registered once. They are due on the cycle after the edge that samples the stimulus. The bench drives each stimulus for one cycle from a falling edge and compares at the following falling edge. The frame strobe is due diag_cycles+1 cycles after the edge that accepts the reset. For each reset that should produce a strobe, the driver queues the expected cycle stamp and signature. A monitor compares every strobe it sees against the front of the queue, so a strobe that is early, late, missing or unexpected is reported.

// File: rtl/sata_srst_pkg.sv
package sata_srst_pkg;

  typedef enum logic {
    PS_RUN   = 1'b0,
    PS_RESET = 1'b1
  } port_state_e;

  localparam int          CTRL_SRST_BIT = 2;
  localparam logic [7:0]  TFD_AT_RESET  = 8'h7F;
  localparam logic [7:0]  TFD_GOOD      = 8'h50;
  localparam logic [31:0] SIG_AT_RESET  = 32'hFFFF_FFFF;

  function automatic logic ctrl_srst(input logic [7:0] ctrl);
    return ctrl[CTRL_SRST_BIT];
  endfunction

  function automatic logic [31:0] sig_pack(input logic [7:0] hi, input logic [7:0] lo,
                                           input logic [7:0] cnt, input logic [7:0] num);
    return {hi, lo, cnt, num};
  endfunction

endpackage

// File: rtl/srst_fsm.sv
module srst_fsm
  import sata_srst_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        frm_valid,
  input  logic        frm_bad,
  input  logic [7:0]  frm_ctrl,
  input  logic        frm_clr_busy,
  input  logic        comreset,
  output port_state_e state,
  output logic        port_rst_ev,
  output logic        srst_clr_ev
);

  logic good_frm;
  logic srst_bit;
  logic enter_reset;
  logic frame_rst_ev;

  assign good_frm     = frm_valid && !frm_bad;
  assign srst_bit     = ctrl_srst(frm_ctrl);
  assign enter_reset  = good_frm && (state == PS_RUN) && srst_bit;
  assign frame_rst_ev = good_frm && (state == PS_RESET) && !srst_bit;
  assign port_rst_ev  = frame_rst_ev || comreset;
  assign srst_clr_ev  = enter_reset && frm_clr_busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= PS_RUN;
    end else if (port_rst_ev) begin
      state <= PS_RUN;
    end else if (enter_reset) begin
      state <= PS_RESET;
    end
  end

endmodule

// File: rtl/pxci_tracker.sv
module pxci_tracker #(
  parameter int SLOTS  = 32,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_we,
  input  logic [SLOTS-1:0]  issue_mask,
  input  logic              cmpl_valid,
  input  logic [SLOT_W-1:0] cmpl_slot,
  input  logic              clr_valid,
  input  logic [SLOT_W-1:0] clr_slot,
  input  logic              zero_all,
  output logic [SLOTS-1:0]  cmd_issue
);

  function automatic logic [SLOTS-1:0] slot_bit(input logic [SLOT_W-1:0] s);
    logic [SLOTS-1:0] m;
    m = '0;
    m[s] = 1'b1;
    return m;
  endfunction

  logic [SLOTS-1:0] set_m;
  logic [SLOTS-1:0] drop_m;

  assign set_m  = issue_we ? issue_mask : '0;
  assign drop_m = (cmpl_valid ? slot_bit(cmpl_slot) : '0) |
                  (clr_valid  ? slot_bit(clr_slot)  : '0);

  for (genvar i = 0; i < SLOTS; i++) begin : g_slot
    always_ff @(posedge clk) begin
      if (!rst_n || zero_all) begin
        cmd_issue[i] <= 1'b0;
      end else begin
        cmd_issue[i] <= (cmd_issue[i] || set_m[i]) && !drop_m[i];
      end
    end
  end

endmodule

// File: rtl/diag_timer.sv
module diag_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] load_val,
  output logic         fire
);

  logic         pending;
  logic [W-1:0] cnt;

  assign fire = pending && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pending <= 1'b0;
      cnt     <= '0;
    end else if (start) begin
      pending <= 1'b1;
      cnt     <= load_val;
    end else if (fire) begin
      pending <= 1'b0;
    end else if (pending) begin
      cnt <= cnt - 1'b1;
    end
  end

endmodule

// File: rtl/sata_srst_port.sv
module sata_srst_port
  import sata_srst_pkg::*;
#(
  parameter int SLOTS  = 32,
  parameter int DIAG_W = 16,
  localparam int SLOT_W = $clog2(SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_we,
  input  logic [SLOTS-1:0]  issue_mask,
  input  logic              cmpl_valid,
  input  logic [SLOT_W-1:0] cmpl_slot,
  input  logic              frm_valid,
  input  logic              frm_bad,
  input  logic [7:0]        frm_ctrl,
  input  logic              frm_clr_busy,
  input  logic [SLOT_W-1:0] frm_slot,
  input  logic              comreset,
  input  logic [DIAG_W-1:0] diag_cycles,
  input  logic [7:0]        tf_cyl_hi,
  input  logic [7:0]        tf_cyl_lo,
  input  logic [7:0]        tf_sec_cnt,
  input  logic [7:0]        tf_sec_num,
  output logic [SLOTS-1:0]  cmd_issue,
  output logic [7:0]        tfd,
  output logic [31:0]       sig,
  output logic              in_reset,
  output logic              init_d2h_sent,
  output logic              d2h_strobe
);

  port_state_e state;
  logic        port_rst_ev;
  logic        srst_clr_ev;
  logic        d2h_fire;

  srst_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .frm_valid    (frm_valid),
    .frm_bad      (frm_bad),
    .frm_ctrl     (frm_ctrl),
    .frm_clr_busy (frm_clr_busy),
    .comreset     (comreset),
    .state        (state),
    .port_rst_ev  (port_rst_ev),
    .srst_clr_ev  (srst_clr_ev)
  );

  pxci_tracker #(.SLOTS(SLOTS)) u_pxci (
    .clk        (clk),
    .rst_n      (rst_n),
    .issue_we   (issue_we),
    .issue_mask (issue_mask),
    .cmpl_valid (cmpl_valid),
    .cmpl_slot  (cmpl_slot),
    .clr_valid  (srst_clr_ev),
    .clr_slot   (frm_slot),
    .zero_all   (port_rst_ev),
    .cmd_issue  (cmd_issue)
  );

  diag_timer #(.W(DIAG_W)) u_diag (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (port_rst_ev),
    .load_val (diag_cycles),
    .fire     (d2h_fire)
  );

  assign in_reset = (state == PS_RESET);

  always_ff @(posedge clk) begin
    if (!rst_n || port_rst_ev) begin
      tfd           <= TFD_AT_RESET;
      sig           <= SIG_AT_RESET;
      init_d2h_sent <= 1'b0;
      d2h_strobe    <= 1'b0;
    end else if (d2h_fire) begin
      tfd           <= TFD_GOOD;
      sig           <= sig_pack(tf_cyl_hi, tf_cyl_lo, tf_sec_cnt, tf_sec_num);
      init_d2h_sent <= 1'b1;
      d2h_strobe    <= 1'b1;
    end else begin
      d2h_strobe    <= 1'b0;
    end
  end

endmodule

// File: rtl/sata_srst_port_chk.sv
module sata_srst_port_chk #(
  parameter int SLOTS = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             issue_we,
  input logic             cmpl_valid,
  input logic             frm_valid,
  input logic             frm_bad,
  input logic [7:0]       frm_ctrl,
  input logic             comreset,
  input logic [SLOTS-1:0] cmd_issue,
  input logic [7:0]       tfd,
  input logic [31:0]      sig,
  input logic             in_reset,
  input logic             init_d2h_sent,
  input logic             d2h_strobe,
  input logic             port_rst_ev
);

  logic quiet_bitmap;
  assign quiet_bitmap = !issue_we && !cmpl_valid && !comreset;

  p_srst_enters_reset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_reset && frm_valid && !frm_bad && frm_ctrl[2] && !comreset) |=> in_reset);

  p_reset_frame_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_reset && frm_valid && !frm_bad && frm_ctrl[2] && quiet_bitmap)
      |=> (in_reset && $stable(cmd_issue)));

  p_port_reset_values_r6: assert property (@(posedge clk) disable iff (!rst_n)
    port_rst_ev |=> (cmd_issue == '0 && tfd == 8'h7F && sig == 32'hFFFF_FFFF &&
                     !init_d2h_sent && !in_reset));

  p_comreset_r7: assert property (@(posedge clk) disable iff (!rst_n)
    comreset |=> (!in_reset && cmd_issue == '0));

  p_strobe_status_r8: assert property (@(posedge clk) disable iff (!rst_n)
    d2h_strobe |-> (tfd == 8'h50 && init_d2h_sent));

  p_bad_frame_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_valid && frm_bad && quiet_bitmap) |=> ($stable(cmd_issue) && $stable(in_reset)));

  p_strobe_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
    d2h_strobe |=> !d2h_strobe);

endmodule

bind sata_srst_port sata_srst_port_chk #(.SLOTS(SLOTS)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .issue_we      (issue_we),
  .cmpl_valid    (cmpl_valid),
  .frm_valid     (frm_valid),
  .frm_bad       (frm_bad),
  .frm_ctrl      (frm_ctrl),
  .comreset      (comreset),
  .cmd_issue     (cmd_issue),
  .tfd           (tfd),
  .sig           (sig),
  .in_reset      (in_reset),
  .init_d2h_sent (init_d2h_sent),
  .d2h_strobe    (d2h_strobe),
  .port_rst_ev   (port_rst_ev)
);

// File: tb/sata_srst_port_tb_top.sv
module sata_srst_port_tb_top;

  localparam int SLOTS  = 32;
  localparam int SW     = $clog2(SLOTS);
  localparam int DIAG_W = 16;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              issue_we = 1'b0;
  logic [SLOTS-1:0]  issue_mask = '0;
  logic              cmpl_valid = 1'b0;
  logic [SW-1:0]     cmpl_slot = '0;
  logic              frm_valid = 1'b0;
  logic              frm_bad = 1'b0;
  logic [7:0]        frm_ctrl = '0;
  logic              frm_clr_busy = 1'b0;
  logic [SW-1:0]     frm_slot = '0;
  logic              comreset = 1'b0;
  logic [DIAG_W-1:0] diag_cycles = 16'd5;
  logic [7:0]        tf_cyl_hi = 8'h00, tf_cyl_lo = 8'h00, tf_sec_cnt = 8'h01, tf_sec_num = 8'h01;
  logic [SLOTS-1:0]  cmd_issue;
  logic [7:0]        tfd;
  logic [31:0]       sig;
  logic              in_reset, init_d2h_sent, d2h_strobe;

  sata_srst_port #(.SLOTS(SLOTS), .DIAG_W(DIAG_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .issue_we(issue_we), .issue_mask(issue_mask),
    .cmpl_valid(cmpl_valid), .cmpl_slot(cmpl_slot), .frm_valid(frm_valid),
    .frm_bad(frm_bad), .frm_ctrl(frm_ctrl), .frm_clr_busy(frm_clr_busy),
    .frm_slot(frm_slot), .comreset(comreset), .diag_cycles(diag_cycles),
    .tf_cyl_hi(tf_cyl_hi), .tf_cyl_lo(tf_cyl_lo), .tf_sec_cnt(tf_sec_cnt),
    .tf_sec_num(tf_sec_num), .cmd_issue(cmd_issue), .tfd(tfd), .sig(sig),
    .in_reset(in_reset), .init_d2h_sent(init_d2h_sent), .d2h_strobe(d2h_strobe)
  );

  always #10 clk = ~clk;

  int  cyc = 0;
  int  checks = 0;
  int  failures = 0;
  bit  done = 1'b0;

  typedef struct {
    int          at;
    logic [31:0] s;
  } exp_t;
  exp_t exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] want);
    checks++;
    if (got !== want) begin
      failures++;
      $display("FAIL %s got=%h exp=%h (cycle %0d)", req, got, want, cyc);
    end
  endtask

  // Monitor: every strobe must match the front of the expectation queue.
  always @(negedge clk) begin
    if (rst_n && d2h_strobe && !done) begin
      checks++;
      if (exp_q.size() == 0) begin
        failures++;
        $display("FAIL R8 unexpected strobe got_cycle=%0d exp=none", cyc);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.at != cyc || sig !== e.s) begin
          failures++;
          $display("FAIL R8 strobe got_cycle=%0d sig=%h exp_cycle=%0d sig=%h", cyc, sig, e.at, e.s);
        end
      end
    end
  end

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000 && !done) begin
      done = 1'b1;
      failures++;
      $display("FAIL watchdog expired at cycle %0d", cyc);
      finish_run();
    end
  end

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic push_strobe();
    exp_t e;
    e.at = cyc + int'(diag_cycles) + 1;
    e.s  = {tf_cyl_hi, tf_cyl_lo, tf_sec_cnt, tf_sec_num};
    exp_q.push_back(e);
  endtask

  task automatic issue(input logic [SLOTS-1:0] m);
    @(negedge clk); issue_we = 1'b1; issue_mask = m;
    @(negedge clk); issue_we = 1'b0; issue_mask = '0;
  endtask

  task automatic complete(input int s);
    @(negedge clk); cmpl_valid = 1'b1; cmpl_slot = SW'(s);
    @(negedge clk); cmpl_valid = 1'b0;
  endtask

  task automatic frame(input logic [7:0] ctrl, input bit clrb, input int s, input bit bad,
                       input bit expect_rst);
    @(negedge clk);
    frm_valid = 1'b1; frm_ctrl = ctrl; frm_clr_busy = clrb; frm_slot = SW'(s); frm_bad = bad;
    @(negedge clk);
    frm_valid = 1'b0; frm_ctrl = '0; frm_clr_busy = 1'b0; frm_bad = 1'b0;
    if (expect_rst) push_strobe();
  endtask

  task automatic pulse_comreset(input bit expect_strobe);
    @(negedge clk); comreset = 1'b1;
    @(negedge clk); comreset = 1'b0;
    if (expect_strobe) push_strobe();
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    check("R1 cmd_issue", cmd_issue, 32'h0);
    check("R1 tfd", 32'(tfd), 32'h7F);
    check("R1 sig", sig, 32'hFFFF_FFFF);
    check("R1 flags", {29'd0, in_reset, init_d2h_sent, d2h_strobe}, 32'h0);

    // R2 issue and complete, including slot 31
    issue(32'h8000_00F1);
    check("R2 issue", cmd_issue, 32'h8000_00F1);
    complete(4);
    check("R2 complete slot4", cmd_issue, 32'h8000_00E1);
    complete(31);
    check("R2 complete slot31", cmd_issue, 32'h0000_00E1);

    // R3 normal frame in run
    frame(8'h00, 1'b1, 0, 1'b0, 1'b0);
    check("R3 stay run", 32'(in_reset), 32'h0);
    check("R3 bitmap kept", cmd_issue, 32'h0000_00E1);

    // R9 bad frame with reset bit
    frame(8'h04, 1'b1, 5, 1'b1, 1'b0);
    check("R9 state", 32'(in_reset), 32'h0);
    check("R9 bitmap", cmd_issue, 32'h0000_00E1);

    // R3/R4 reset-assert without clear-busy
    frame(8'h04, 1'b0, 5, 1'b0, 1'b0);
    check("R3 enter reset", 32'(in_reset), 32'h1);
    check("R4 no clr", cmd_issue, 32'h0000_00E1);

    // R5 reset bit still set while in reset
    frame(8'h0C, 1'b1, 6, 1'b0, 1'b0);
    check("R5 still reset", 32'(in_reset), 32'h1);
    check("R5 bitmap", cmd_issue, 32'h0000_00E1);

    // R6 reset-deassert frame, with issue in the same cycle
    tf_cyl_hi = 8'hEB; tf_cyl_lo = 8'h14; tf_sec_cnt = 8'h01; tf_sec_num = 8'h01;
    @(negedge clk);
    issue_we = 1'b1; issue_mask = 32'h0000_0300;
    frm_valid = 1'b1; frm_ctrl = 8'h00; frm_slot = 7;
    @(negedge clk);
    issue_we = 1'b0; issue_mask = '0; frm_valid = 1'b0;
    push_strobe();
    check("R6 bitmap zero", cmd_issue, 32'h0);
    check("R6 tfd", 32'(tfd), 32'h7F);
    check("R6 sig", sig, 32'hFFFF_FFFF);
    check("R6 flags", {30'd0, in_reset, init_d2h_sent}, 32'h0);
    idle(int'(diag_cycles) + 2);
    // R8 status after first D2H
    check("R8 tfd good", 32'(tfd), 32'h50);
    check("R8 init sent", 32'(init_d2h_sent), 32'h1);
    check("R8 sig", sig, 32'hEB14_0101);

    // R4 reset-assert with clear-busy
    issue(32'h0000_0021);
    frame(8'h04, 1'b1, 5, 1'b0, 1'b0);
    check("R4 clr slot5", cmd_issue, 32'h0000_0001);
    check("R4 state", 32'(in_reset), 32'h1);
    idle(10);
    check("R4 no strobe queue", exp_q.size(), 32'h0);

    // R7 comreset from reset state
    tf_cyl_hi = 8'h96; tf_cyl_lo = 8'h69; tf_sec_cnt = 8'h3C; tf_sec_num = 8'hA5;
    pulse_comreset(1'b1);
    check("R7 state", 32'(in_reset), 32'h0);
    check("R7 bitmap", cmd_issue, 32'h0);
    idle(int'(diag_cycles) + 2);
    check("R7 sig", sig, 32'h9669_3CA5);

    // R10 restart during delay
    issue(32'h0000_0010);
    pulse_comreset(1'b0);
    idle(2);
    tf_sec_num = 8'h5A;
    pulse_comreset(1'b1);
    idle(int'(diag_cycles) + 8);
    check("R10 queue drained", exp_q.size(), 32'h0);
    check("R10 sig", sig, 32'h9669_3C5A);

    // R8 zero delay
    diag_cycles = '0;
    tf_cyl_hi = 8'hC3;
    pulse_comreset(1'b1);
    idle(3);
    check("R8 zero-delay queue", exp_q.size(), 32'h0);
    check("R8 zero-delay sig", sig, 32'hC369_3C5A);

    idle(2);
    check("R8 no leftover", exp_q.size(), 32'h0);
    done = 1'b1;
    finish_run();
  end

endmodule